// File: doc/BRIEF.md
# Parallel flash command sequencer

This block sits behind the host side of a byte-wide parallel flash device and turns host write cycles into array operations. Every write is taken when the combined chip-enable/write-enable strobe ends. The multi-write unlock sequences are decoded from the data byte alone: the address of an unlock cycle is never compared. A recognised program or sector-erase sequence is handed to an array engine as a request. While an operation is in progress, host reads return a status byte instead of array data. The block also supports a shortened program sequence, erase suspend with resume, per-sector write protection, a low-supply write lock and an asynchronous hardware reset.

The engine port is a valid/ready request channel with a separate completion pulse. A request, with its operation type, address and data, stays valid and unchanged until the engine raises ready. The engine may hold ready low for any number of cycles. Only one request is outstanding at a time. The engine signals completion of that request with a one-cycle `eng_done` pulse. When no operation is running, host reads return `arr_rdata`, which the array supplies directly from the host address.

Sector erase collects sectors into a mask. Each extra sector write restarts a window of `ERASE_WIN` cycles, and the erase starts when the window runs out. Sectors are then erased one request at a time, lowest index first.

Top module: `pflash_seq`

## Requirements
- R1: The writes AA, 55, A0 followed by a data write issue one program request (`eng_req_erase`=0) carrying the address and data of that fourth write.
- R2: The writes AA, 55, 20 enter bypass mode. In bypass mode the pair A0 then data issues a program request. The pair 90 then 00 leaves bypass mode, after which A0 then data issues nothing.
- R3: Unlock and command cycles are accepted whatever their address; only the data byte is decoded.
- R4: A data byte that does not fit the sequence in progress returns the block to read mode without issuing a request.
- R5: The writes AA, 55, 80, AA, 55 followed by 30 at a sector address start an erase. Each further 30 that arrives within `ERASE_WIN` cycles of the previous one adds its sector. Every selected sector is then requested once (`eng_req_erase`=1, address = sector index in bits 21:16 with zero below), in ascending order.
- R6: A program or erase whose sector (address bits 21:16) has its `prot_mask` bit set produces no request, and a blocked program leaves `rdy_bsy` high.
- R7: B0 during an erase suspends it once the outstanding sector finishes. While suspended, a four-write program to a sector that is not selected is issued, a program to a selected sector is blocked, and 30 resumes the remaining sectors.
- R8: While `hard_rst_n` is low, `rdy_bsy` is 1, no request is valid and reads return `arr_rdata`. Any operation in progress is abandoned.
- R9: `rdy_bsy` is 0 from the write that starts an operation until that operation completes, and 1 otherwise.
- R10: While busy, a read returns {DQ7, DQ6, 000000}. DQ7 is the complement of bit 7 of the data being programmed, or 0 during an erase. DQ6 inverts after each completed read. When idle, a read returns array data.
- R11: Writes that end while `lowv` is high are discarded.
- R12: While busy, writes are ignored, except B0 during an erase.
- R13: A request that is valid while `eng_req_ready` is low stays valid with unchanged fields on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 22 | Byte address |
| wdata | input | 8 | Host write data |
| lowv | input | 1 | Low-supply flag, blocks writes |
| prot_mask | input | 64 | One protect bit per sector |
| arr_rdata | input | 8 | Array data at the host address |
| rdata | output | 8 | Read data: array byte or status |
| rdy_bsy | output | 1 | 1 = ready, 0 = busy |
| eng_req_valid | output | 1 | Engine request valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_erase | output | 1 | 1 = sector erase, 0 = byte program |
| eng_req_addr | output | 22 | Program address or sector base |
| eng_req_data | output | 8 | Program data (FF for erase) |
| eng_done | input | 1 | One-cycle completion pulse |

## Verification
The assertions rely on several assumptions about the surroundings:
- `prot_mask` does not change while an operation is pending.
- The engine pulses `eng_done` only once for each accepted request, and never before accepting it.
- Host address and data are stable while the write strobe is low.
- Read and write strobes never overlap.

The stimulus meets these assumptions. The engine stub holds at most one request and finishes it after a fixed latency. The bench writes and reads through tasks that hold the bus steady for a full cycle. The protect pattern is set once and never changed.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [4:0] {
    ST_READ, ST_U1, ST_U2, ST_PGD, ST_E1, ST_E2, ST_E3, ST_EWIN,
    ST_BYP, ST_BPG, ST_BEX, ST_PGBUSY, ST_ERBUSY,
    ST_SUSP, ST_SU1, ST_SU2, ST_SPG
  } fsm_t;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERSU  = 8'h80;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_BEX1  = 8'h90;
  localparam logic [7:0] C_BEX2  = 8'h00;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_RES   = 8'h30;
endpackage

// File: rtl/pflash_wsync.sv
module pflash_wsync #(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          inhibit,
  output logic          cmd_fire,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          rd_done
);
  logic wstb, wstb_q, rstb, rstb_q;

  assign wstb = ~ce_n & ~we_n;
  assign rstb = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstb_q   <= 1'b0;
      rstb_q   <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      wstb_q <= wstb;
      rstb_q <= rstb;
      if (wstb) begin
        cmd_addr <= addr;
        cmd_data <= wdata;
      end
    end
  end

  // a write counts when the strobe ends; the supply lock drops it
  assign cmd_fire = wstb_q & ~wstb & ~inhibit;
  assign rd_done  = rstb_q & ~rstb;
endmodule

// File: rtl/pflash_sect_q.sv
module pflash_sect_q #(
  parameter int NSECT = 64,
  localparam int SW   = $clog2(NSECT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [SW-1:0] add_idx,
  input  logic          drop_en,
  input  logic [SW-1:0] query_idx,
  output logic          any,
  output logic [SW-1:0] cur_idx,
  output logic          hit
);
  logic [NSECT-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else begin
      if (clr)     mask <= '0;
      if (add_en)  mask[add_idx] <= 1'b1;
      if (drop_en) mask[cur_idx] <= 1'b0;
    end
  end

  always_comb begin
    cur_idx = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (mask[i]) cur_idx = SW'(i);
    end
  end

  assign any = |mask;
  assign hit = mask[query_idx];

  AST_DROP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |-> mask[cur_idx]); // R5
endmodule

// File: rtl/pflash_stat.sv
module pflash_stat #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          dq7,
  input  logic          rd_done,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rdata,
  output logic          rdy
);
  logic tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tog <= 1'b0;
    else if (busy && rd_done) tog <= ~tog;
  end

  assign rdata = busy ? {dq7, tog, {(DW-2){1'b0}}} : arr_rdata;
  assign rdy   = ~busy;

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog)); // R10
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int SECT_W    = 6,
  parameter int ERASE_WIN = 32,
  localparam int NSECT    = 1 << SECT_W,
  localparam int OFF_W    = ADDR_W - SECT_W,
  localparam int WIN_W    = $clog2(ERASE_WIN + 1)
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              lowv,
  input  logic [NSECT-1:0]  prot_mask,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rdata,
  output logic              rdy_bsy,
  output logic              eng_req_valid,
  input  logic              eng_req_ready,
  output logic              eng_req_erase,
  output logic [ADDR_W-1:0] eng_req_addr,
  output logic [7:0]        eng_req_data,
  input  logic              eng_done
);
  fsm_t              st, pg_ret;
  logic [ADDR_W-1:0] req_a;
  logic [7:0]        req_d;
  logic              issued, susp_pend;
  logic [WIN_W-1:0]  win_cnt;

  logic              cmd_fire, rd_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic [SECT_W-1:0] cmd_sect, q_cur;
  logic              prot_hit, q_any, q_hit, q_clr, q_add, q_drop;
  logic              busy, dq7, pg_block, b0;

  pflash_wsync #(.AW(ADDR_W), .DW(8)) u_wsync (
    .clk(clk), .rst_n(hard_rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .inhibit(lowv),
    .cmd_fire(cmd_fire), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_done(rd_done)
  );

  assign cmd_sect = cmd_addr[ADDR_W-1 -: SECT_W];
  assign prot_hit = prot_mask[cmd_sect];
  assign b0       = cmd_fire && (cmd_data == C_SUSP);

  assign q_clr  = (st == ST_E3) && cmd_fire && (cmd_data == C_SECT);
  assign q_add  = cmd_fire && (cmd_data == C_SECT) && !prot_hit &&
                  ((st == ST_E3) || (st == ST_EWIN));
  assign q_drop = (st == ST_ERBUSY) && issued && eng_done;

  pflash_sect_q #(.NSECT(NSECT)) u_queue (
    .clk(clk), .rst_n(hard_rst_n), .clr(q_clr), .add_en(q_add),
    .add_idx(cmd_sect), .drop_en(q_drop), .query_idx(cmd_sect),
    .any(q_any), .cur_idx(q_cur), .hit(q_hit)
  );

  assign pg_block = prot_hit || ((st == ST_SPG) && q_hit);
  assign busy     = (st == ST_PGBUSY) || (st == ST_ERBUSY) || (st == ST_EWIN);
  assign dq7      = (st == ST_PGBUSY) ? ~req_d[7] : 1'b0;

  pflash_stat #(.DW(8)) u_stat (
    .clk(clk), .rst_n(hard_rst_n), .busy(busy), .dq7(dq7),
    .rd_done(rd_done), .arr_rdata(arr_rdata), .rdata(rdata), .rdy(rdy_bsy)
  );

  assign eng_req_valid = !issued &&
                         ((st == ST_PGBUSY) || ((st == ST_ERBUSY) && q_any));
  assign eng_req_erase = (st == ST_ERBUSY);
  assign eng_req_addr  = (st == ST_ERBUSY) ? {q_cur, {OFF_W{1'b0}}} : req_a;
  assign eng_req_data  = (st == ST_ERBUSY) ? 8'hFF : req_d;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      st        <= ST_READ;
      pg_ret    <= ST_READ;
      req_a     <= '0;
      req_d     <= '0;
      issued    <= 1'b0;
      susp_pend <= 1'b0;
      win_cnt   <= '0;
    end else begin
      unique case (st)
        ST_READ: if (cmd_fire && cmd_data == C_UNLK1) st <= ST_U1;
        ST_U1:   if (cmd_fire) st <= (cmd_data == C_UNLK2) ? ST_U2 : ST_READ;
        ST_U2: if (cmd_fire) begin
          unique case (cmd_data)
            C_PROG:  st <= ST_PGD;
            C_ERSU:  st <= ST_E1;
            C_BYP:   st <= ST_BYP;
            default: st <= ST_READ;
          endcase
        end
        ST_PGD: if (cmd_fire) begin
          if (pg_block) st <= ST_READ;
          else begin
            req_a <= cmd_addr; req_d <= cmd_data;
            pg_ret <= ST_READ; st <= ST_PGBUSY;
          end
        end
        ST_E1: if (cmd_fire) st <= (cmd_data == C_UNLK1) ? ST_E2 : ST_READ;
        ST_E2: if (cmd_fire) st <= (cmd_data == C_UNLK2) ? ST_E3 : ST_READ;
        ST_E3: if (cmd_fire) begin
          if (cmd_data == C_SECT) begin
            st      <= ST_EWIN;
            win_cnt <= WIN_W'(ERASE_WIN);
          end else st <= ST_READ;
        end
        ST_EWIN: begin
          if (cmd_fire) begin
            if (cmd_data == C_SECT) win_cnt <= WIN_W'(ERASE_WIN);
            else st <= ST_READ;
          end else if (win_cnt == '0) begin
            st        <= q_any ? ST_ERBUSY : ST_READ;
            issued    <= 1'b0;
            susp_pend <= 1'b0;
          end else begin
            win_cnt <= win_cnt - 1'b1;
          end
        end
        ST_PGBUSY: begin
          if (!issued) begin
            if (eng_req_ready) issued <= 1'b1;
          end else if (eng_done) begin
            issued <= 1'b0;
            st     <= pg_ret;
          end
        end
        ST_ERBUSY: begin
          if (b0) susp_pend <= 1'b1;
          if (issued) begin
            if (eng_done) begin
              issued <= 1'b0;
              if (susp_pend || b0) begin
                st        <= ST_SUSP;
                susp_pend <= 1'b0;
              end
            end
          end else if (!q_any) begin
            st        <= ST_READ;
            susp_pend <= 1'b0;
          end else if (eng_req_ready) begin
            issued <= 1'b1;
          end
        end
        ST_SUSP: if (cmd_fire) begin
          if (cmd_data == C_UNLK1)    st <= ST_SU1;
          else if (cmd_data == C_RES) st <= ST_ERBUSY;
        end
        ST_SU1: if (cmd_fire) st <= (cmd_data == C_UNLK2) ? ST_SU2 : ST_SUSP;
        ST_SU2: if (cmd_fire) st <= (cmd_data == C_PROG) ? ST_SPG : ST_SUSP;
        ST_SPG: if (cmd_fire) begin
          if (pg_block) st <= ST_SUSP;
          else begin
            req_a <= cmd_addr; req_d <= cmd_data;
            pg_ret <= ST_SUSP; st <= ST_PGBUSY;
          end
        end
        ST_BYP: if (cmd_fire) begin
          if (cmd_data == C_PROG)      st <= ST_BPG;
          else if (cmd_data == C_BEX1) st <= ST_BEX;
        end
        ST_BPG: if (cmd_fire) begin
          if (pg_block) st <= ST_BYP;
          else begin
            req_a <= cmd_addr; req_d <= cmd_data;
            pg_ret <= ST_BYP; st <= ST_PGBUSY;
          end
        end
        ST_BEX: if (cmd_fire) st <= (cmd_data == C_BEX2) ? ST_READ : ST_BYP;
        default: st <= ST_READ;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    eng_req_valid && !eng_req_ready |=> eng_req_valid && $stable(eng_req_addr)
      && $stable(eng_req_data) && $stable(eng_req_erase)); // R13
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!hard_rst_n)
    eng_req_valid |-> !rdy_bsy); // R9
  AST_PROT_GUARD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    eng_req_valid |-> !prot_mask[eng_req_addr[ADDR_W-1 -: SECT_W]]); // R6
endmodule

// File: tb/pflash_seq_test.sv
module pflash_seq_test;
  localparam int LAT = 40;
  localparam logic [63:0] PROT = 64'hA5A5_0F0F_3C3C_9999;

  logic        clk = 1'b0;
  logic        hard_rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [21:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        lowv = 1'b0;
  logic [7:0]  arr_rdata = 8'h3C;
  logic [7:0]  rdata;
  logic        rdy_bsy, eng_req_valid, eng_req_erase, eng_done;
  logic [21:0] eng_req_addr;
  logic [7:0]  eng_req_data;
  logic        stall = 1'b0;
  logic        eng_req_ready;

  int n_chk = 0, n_bad = 0, n_req = 0, lat_cnt = 0;
  logic        lg_erase [256];
  logic [21:0] lg_addr  [256];
  logic [7:0]  lg_data  [256];

  always #5 clk = ~clk;
  assign eng_req_ready = ~stall;

  pflash_seq uut (
    .clk(clk), .hard_rst_n(hard_rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .lowv(lowv), .prot_mask(PROT),
    .arr_rdata(arr_rdata), .rdata(rdata), .rdy_bsy(rdy_bsy),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
    .eng_req_erase(eng_req_erase), .eng_req_addr(eng_req_addr),
    .eng_req_data(eng_req_data), .eng_done(eng_done)
  );

  // array engine stub: fixed latency, one request at a time
  always @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      lat_cnt  <= 0;
      eng_done <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (lat_cnt > 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) eng_done <= 1'b1;
      end
      if (eng_req_valid && eng_req_ready) begin
        lat_cnt <= LAT;
        lg_erase[n_req % 256] <= eng_req_erase;
        lg_addr[n_req % 256]  <= eng_req_addr;
        lg_data[n_req % 256]  <= eng_req_data;
        n_req <= n_req + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    #1 v = rdata;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  // R3: unlock addresses vary with k
  task automatic prog(input int k, input logic [21:0] a, input logic [7:0] d);
    wr(22'(k * 12345 + 7), 8'hAA);
    wr(22'(k * 54321 + 99), 8'h55);
    wr(22'(k * 777), 8'hA0);
    wr(a, d);
  endtask

  task automatic erase_start(input logic [21:0] a);
    wr(22'h0, 8'hAA); wr(22'h3FFFFF, 8'h55); wr(22'h12, 8'h80);
    wr(22'h5, 8'hAA); wr(22'h7, 8'h55); wr(a, 8'h30);
  endtask

  task automatic wait_rdy(input string tag);
    int t = 0;
    while (!rdy_bsy && t < 5000) begin @(negedge clk); t++; end
    chk(rdy_bsy, tag, rdy_bsy, 1);
  endtask

  task automatic wait_req(input int target);
    int t = 0;
    while (n_req < target && t < 500) begin @(negedge clk); t++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v1, v2;
    int base, ei, exp_n;
    logic [63:0] sel;
    logic [21:0] a;
    logic [7:0] d;

    repeat (3) @(negedge clk);
    // R8: state during reset
    chk(rdy_bsy == 1'b1, "R8 rdy in reset", rdy_bsy, 1);
    chk(eng_req_valid == 1'b0, "R8 valid in reset", eng_req_valid, 0);
    chk(rdata == 8'h3C, "R8 read in reset", rdata, 8'h3C);
    hard_rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R6 R9 R10: program every sector under the protect pattern
    for (int s = 0; s < 64; s++) begin
      a = {6'(s), 16'(s * 977)};
      d = 8'(s * 37 + 3);
      base = n_req;
      prog(s, a, d);
      if (PROT[s]) begin
        chk(rdy_bsy == 1'b1, "R6 protected program stays ready", rdy_bsy, 1);
        repeat (3) @(negedge clk);
        chk(n_req == base, "R6 protected program no request", n_req, base);
      end else begin
        chk(rdy_bsy == 1'b0, "R9 busy after program", rdy_bsy, 0);
        rd(v1); rd(v2);
        chk(v1[7] == ~d[7], "R10 DQ7 complement", v1[7], ~d[7]);
        chk(v1[6] != v2[6], "R10 DQ6 toggles", v2[6], ~v1[6]);
        wait_rdy("R9 ready after program");
        rd(v1);
        chk(v1 == 8'h3C, "R10 array data when done", v1, 8'h3C);
        chk(n_req == base + 1, "R1 one request", n_req, base + 1);
        chk(lg_erase[base % 256] == 1'b0 && lg_addr[base % 256] == a
            && lg_data[base % 256] == d, "R1 request fields",
            int'(lg_addr[base % 256]), int'(a));
      end
    end

    // R4: wrong bytes abort
    base = n_req;
    wr(22'h1, 8'hAA); wr(22'h2, 8'h54); wr(22'h3, 8'hA0); wr(22'h010000, 8'h11);
    erase_start(22'h0); // sequence ok, check a broken one next
    wait_rdy("R4 setup");
    base = n_req;
    wr(22'h0, 8'hAA); wr(22'h0, 8'h55); wr(22'h0, 8'h80);
    wr(22'h0, 8'hAA); wr(22'h0, 8'h77); wr(22'h020000, 8'h30);
    repeat (60) @(negedge clk);
    chk(n_req == base && rdy_bsy, "R4 broken erase no request", n_req, base);
    prog(3, 22'h060000, 8'h5A);
    wait_rdy("R4 recover");
    chk(n_req == base + 1, "R4 program after abort", n_req, base + 1);

    // R2: bypass program
    wr(22'h0, 8'hAA); wr(22'h0, 8'h55); wr(22'h0, 8'h20);
    for (int k = 0; k < 4; k++) begin
      base = n_req;
      a = {6'd2, 16'(k * 301)};
      wr(a, 8'hA0); wr(a, 8'(k + 8'h40));
      wait_rdy("R2 bypass ready");
      chk(n_req == base + 1 && lg_data[base % 256] == 8'(k + 8'h40),
          "R2 bypass program", int'(lg_data[base % 256]), k + 8'h40);
    end
    base = n_req;
    wr(22'h040000, 8'hA0); wr(22'h040000, 8'h01); // sector 4 protected: R6
    chk(n_req == base && rdy_bsy, "R6 bypass protected", n_req, base);
    wr(22'h0, 8'h90); wr(22'h0, 8'h00);
    wr(22'h020000, 8'hA0); wr(22'h020000, 8'h01);
    repeat (5) @(negedge clk);
    chk(n_req == base, "R2 exit bypass", n_req, base);

    // R5: multi-sector erase, ascending, protected ones skipped
    sel = '0;
    sel[40] = 1; sel[3] = 1; sel[17] = 1; sel[8] = 1; sel[1] = 1;
    base = n_req;
    erase_start(22'(40) << 16);
    wr(22'(3) << 16, 8'h30); wr(22'(17) << 16, 8'h30);
    wr(22'(3) << 16, 8'h30); wr(22'(8) << 16, 8'h30); wr(22'(1) << 16, 8'h30);
    rd(v1);
    chk(v1[7] == 1'b0 && rdy_bsy == 1'b0, "R10 DQ7 zero in erase", v1, 0);
    wait_rdy("R5 erase done");
    exp_n = 0;
    for (int s = 0; s < 64; s++) begin
      if (sel[s] && !PROT[s]) begin
        ei = base + exp_n;
        chk(lg_erase[ei % 256] == 1'b1 && lg_addr[ei % 256] == (22'(s) << 16),
            "R5 erase order", int'(lg_addr[ei % 256]), s << 16);
        exp_n++;
      end
    end
    chk(n_req == base + exp_n, "R5 erase count", n_req - base, exp_n);

    // R7: suspend, program elsewhere, blocked in selected, resume
    base = n_req;
    erase_start(22'h010000); wr(22'h020000, 8'h30); wr(22'h050000, 8'h30);
    wait_req(base + 1);
    wr(22'h0, 8'hB0);
    chk(rdy_bsy == 1'b0, "R7 still busy until sector ends", rdy_bsy, 0);
    wait_rdy("R7 suspended ready");
    chk(n_req == base + 1, "R7 one sector before suspend", n_req, base + 1);
    prog(9, 22'h061234, 8'h99);
    chk(rdy_bsy == 1'b0, "R7 program in suspend busy", rdy_bsy, 0);
    wait_rdy("R7 program in suspend done");
    chk(n_req == base + 2 && lg_addr[(base + 1) % 256] == 22'h061234,
        "R7 program in suspend", int'(lg_addr[(base + 1) % 256]), 22'h061234);
    prog(10, 22'h020010, 8'h12);
    repeat (3) @(negedge clk);
    chk(n_req == base + 2 && rdy_bsy, "R7 selected sector blocked", n_req, base + 2);
    wr(22'h0, 8'h30);
    wait_rdy("R7 resume done");
    chk(n_req == base + 4 && lg_addr[(base + 2) % 256] == 22'h020000
        && lg_addr[(base + 3) % 256] == 22'h050000, "R7 resumed order",
        int'(lg_addr[(base + 3) % 256]), 22'h050000);

    // R12: writes during busy ignored, B0 during program ignored
    base = n_req;
    prog(11, 22'h010020, 8'h21);
    wr(22'h0, 8'hAA); wr(22'h0, 8'h55); wr(22'h0, 8'hB0);
    chk(rdy_bsy == 1'b0, "R12 B0 ignored in program", rdy_bsy, 0);
    wait_rdy("R12 done");
    wr(22'h010030, 8'hA0); wr(22'h010030, 8'h22);
    repeat (3) @(negedge clk);
    chk(n_req == base + 1, "R12 busy writes dropped", n_req, base + 1);

    // R11: low-supply lock
    base = n_req;
    lowv = 1'b1;
    prog(12, 22'h010040, 8'h33);
    chk(rdy_bsy == 1'b1, "R11 no busy under lock", rdy_bsy, 1);
    wr(22'h0, 8'hAA);
    lowv = 1'b0;
    wr(22'h0, 8'h55); wr(22'h0, 8'hA0); wr(22'h010040, 8'h33);
    repeat (3) @(negedge clk);
    chk(n_req == base, "R11 locked writes dropped", n_req, base);

    // R13: back-pressure holds the request
    base = n_req;
    stall = 1'b1;
    prog(13, 22'h051111, 8'h77);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(eng_req_valid && eng_req_addr == 22'h051111 && eng_req_data == 8'h77,
          "R13 held request", int'(eng_req_addr), 22'h051111);
    end
    stall = 1'b0;
    wait_rdy("R13 done");
    chk(n_req == base + 1, "R13 single accept", n_req, base + 1);

    // R8: hardware reset aborts an erase
    base = n_req;
    erase_start(22'h010000); wr(22'h020000, 8'h30);
    wait_req(base + 1);
    @(negedge clk);
    hard_rst_n = 1'b0;
    @(negedge clk);
    chk(rdy_bsy == 1'b1 && !eng_req_valid, "R8 abort", rdy_bsy, 1);
    chk(rdata == 8'h3C, "R8 array read after abort", rdata, 8'h3C);
    hard_rst_n = 1'b1;
    repeat (150) @(negedge clk);
    chk(n_req == base + 1 && rdy_bsy, "R8 no further erase", n_req, base + 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule